// File: doc/BRIEF.md
# Dual-Bank RGB Colour Matrix Remap

This block remaps each incoming RGB pixel through a 3x3 colour matrix and adds one offset per output channel. It keeps two complete coefficient sets, set A and set B. Software loads the idle set while the pixel path uses the other set. It then selects the freshly loaded set through a mode code. The mode code also encodes a bypass setting.

The requested mode and the coefficient format are copied into the active state only on a frame-start pulse, so a frame never mixes two matrices. The active mode can be read back at all times. Software uses it ping-pong style: when set A is active, it loads set B and then requests set B, and the reverse when set B is active. Every pixel takes three clock cycles from input to output. A valid flag travels alongside the data, and bypass has the same latency.

Top module: `rgb_remap_matrix`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `mode_active` is 0, `pix_valid_out` is 0 and all three pixel outputs are 0. Both coefficient sets reset to all zero.
- R2: `mode_req` and `fmt_req` are copied into the active state only on a clock edge where `frame_start` is 1. At any other edge `mode_active` holds its value, and a changed request has no effect on the pixel results.
- R3: Mode codes are as follows: 0 is bypass, 1 uses set A and 2 uses set B. Code 3 is reserved; it acts as bypass and reads back on `mode_active` as 0.
- R4: In bypass, each output channel equals the matching input channel, with the same three-cycle latency as the matrix path.
- R5: Output channel i (0 = red, 1 = green, 2 = blue) equals Ci0*R + Ci1*G + Ci2*B + Ci3. The coefficient with index k = 4*i + j is stored in word k/2 of a set. Even k sits in bits 15:0 of `cfg_wr_data` and odd k sits in bits 31:16. Word numbers 6 and 7 are ignored.
- R6: With format 0, the multiplier coefficients are signed with 2 integer and 13 fraction bits, so 8192 means 1.0. With format 1 they are signed with 3 integer and 12 fraction bits, so 4096 means 1.0. The offset Ci3 is always a signed whole number of output codes.
- R7: The result is rounded to the nearest integer, with an exact half rounding upward. It is then clamped to 0..4095.
- R8: A pixel presented with `pix_valid_in` at a rising edge appears with `pix_valid_out` high exactly three edges later. Pixels may arrive on every cycle.
- R9: Writes to the set that is not in use do not change the output. Switching to bypass and back leaves both sets intact.
- R10: `cfg_wr_set` selects the target of a write: 0 targets set A and 1 targets set B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Coefficient word write strobe |
| cfg_wr_set | input | 1 | Target set: 0 = A, 1 = B |
| cfg_wr_word | input | 3 | Word number within the set (0..5) |
| cfg_wr_data | input | 32 | Two 16-bit coefficients, even index in the low half |
| mode_req | input | 2 | Requested mode code |
| fmt_req | input | 1 | Requested coefficient format |
| frame_start | input | 1 | Frame boundary pulse; loads the requests |
| pix_valid_in | input | 1 | Input pixel valid |
| pix_r_in | input | 12 | Input red |
| pix_g_in | input | 12 | Input green |
| pix_b_in | input | 12 | Input blue |
| pix_valid_out | output | 1 | Output pixel valid |
| pix_r_out | output | 12 | Output red |
| pix_g_out | output | 12 | Output green |
| pix_b_out | output | 12 | Output blue |
| mode_active | output | 2 | Mode currently applied to pixels |

## Verification
The matrix path is tried with three kinds of matrix.
- An identity matrix with positive and negative offsets shows whether offsets land on the right channel.
- A channel-swapping matrix with half-weight terms separates set A from set B and exercises round-half-up.
- The identity coefficients read under the other format show whether the fraction point moves: the same word must give a doubled gain.

Extreme pixels drive the sum past 4095 and below zero to exercise the clamp. A run of back-to-back distinct pixels shows that consecutive results are neither skewed nor mixed. Mode requests made without a frame pulse, the reserved code, and a bypass interval between uses of set B show that the swap is synchronised and that the stored sets survive.

// File: rtl/remap_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the colour matrix remap: mode codes and the
// mapping from a requested code to the mode actually applied.
package remap_pkg;

    typedef enum logic [1:0] {
        MODE_BYPASS = 2'd0,
        MODE_SET_A  = 2'd1,
        MODE_SET_B  = 2'd2,
        MODE_RSVD   = 2'd3
    } remap_mode_e;

    // The reserved code is folded into bypass before it is stored.
    function automatic remap_mode_e effective_mode(input logic [1:0] code);
        return (code == 2'd3) ? MODE_BYPASS : remap_mode_e'(code);
    endfunction

endpackage

// File: rtl/remap_mode_ctrl.sv
`timescale 1ns/1ps
// Holds the active mode and coefficient format. Requests are sampled only on
// a frame-start pulse, so one frame always uses one matrix. Assumes
// frame_start is a single-cycle pulse synchronous to clk.
module remap_mode_ctrl
    import remap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_start,
    input  logic [1:0]  mode_code,
    input  logic        fmt_code,
    output remap_mode_e cur_mode,
    output logic        cur_fmt
);

    // Load the requested mode and format at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_mode <= MODE_BYPASS;
            cur_fmt  <= 1'b0;
        end else if (frame_start) begin
            cur_mode <= effective_mode(mode_code);
            cur_fmt  <= fmt_code;
        end
    end

    p_hold_between_frames_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(cur_mode) && $stable(cur_fmt)));

    p_load_on_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && mode_code != 2'd3) |=> (cur_mode == $past(mode_code)));

    p_reserved_is_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && mode_code == 2'd3) |=> (cur_mode == MODE_BYPASS));

endmodule

// File: rtl/remap_coef_store.sv
`timescale 1ns/1ps
// Two banks of matrix coefficients, written two per word from the host side.
// One bank is presented flat to the datapath according to rd_bank.
// Word numbers at or above NUM_COEF/2 are ignored.
module remap_coef_store #(
    parameter int COEF_W   = 16,
    parameter int NUM_COEF = 12
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic                             wr_bank,
    input  logic [$clog2(NUM_COEF/2)-1:0]    wr_word,
    input  logic [2*COEF_W-1:0]              wr_data,
    input  logic                             rd_bank,
    output logic [NUM_COEF*COEF_W-1:0]       rd_coefs
);
    localparam int NUM_WORDS = NUM_COEF / 2;
    localparam int NUM_BANKS = 2;

    logic [NUM_BANKS-1:0][NUM_COEF*COEF_W-1:0] bank_flat;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [NUM_COEF-1:0][COEF_W-1:0] regs;

        // Store both halves of a word written to this bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs <= '0;
            end else if (wr_en && (int'(wr_bank) == b) && (int'(wr_word) < NUM_WORDS)) begin
                regs[2*int'(wr_word)]     <= wr_data[COEF_W-1:0];
                regs[2*int'(wr_word) + 1] <= wr_data[2*COEF_W-1:COEF_W];
            end
        end

        assign bank_flat[b] = regs;
    end

    assign rd_coefs = bank_flat[rd_bank];

    p_idle_write_invisible_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_bank != rd_bank) |=> ((rd_bank != $past(rd_bank)) || $stable(rd_coefs)));

endmodule

// File: rtl/remap_lane.sv
`timescale 1ns/1ps
// One output channel of the matrix: three products plus an offset, rounded,
// shifted by the format's fraction width and clamped, over three registered
// stages. In bypass the selected input component rides the same stages.
// Assumes the coefficient row is ordered C0 (red), C1, C2, C3 (offset).
module remap_lane #(
    parameter int PIX_W   = 12,
    parameter int COEF_W  = 16,
    parameter int FRAC_F0 = 13,
    parameter int FRAC_F1 = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bypass,
    input  logic                  fmt_sel,
    input  logic [4*COEF_W-1:0]   coef_row,
    input  logic [PIX_W-1:0]      pix_r,
    input  logic [PIX_W-1:0]      pix_g,
    input  logic [PIX_W-1:0]      pix_b,
    input  logic [PIX_W-1:0]      pix_pass,
    output logic [PIX_W-1:0]      pix_out
);
    localparam int PROD_W  = COEF_W + PIX_W + 1;
    localparam int ACC_W   = PROD_W + 3;
    localparam int MAX_PIX = (1 << PIX_W) - 1;
    localparam logic signed [ACC_W-1:0] HALF_F0 = ACC_W'(1) << (FRAC_F0 - 1);
    localparam logic signed [ACC_W-1:0] HALF_F1 = ACC_W'(1) << (FRAC_F1 - 1);

    logic signed [PROD_W-1:0] c_ext [3];
    logic signed [PROD_W-1:0] p_ext [3];
    logic signed [ACC_W-1:0]  off_ext;
    logic signed [ACC_W-1:0]  off_term;

    logic signed [PROD_W-1:0] s1_prod [3];
    logic signed [ACC_W-1:0]  s1_off;
    logic                     s1_byp, s1_fmt;
    logic [PIX_W-1:0]         s1_pass;

    logic signed [ACC_W-1:0]  s2_sum;
    logic                     s2_byp, s2_fmt;
    logic [PIX_W-1:0]         s2_pass;

    logic signed [ACC_W-1:0]  shifted;
    logic [PIX_W-1:0]         clamped;

    // Widen coefficients (signed) and pixels (unsigned) to product width.
    always_comb begin
        for (int k = 0; k < 3; k++) begin
            c_ext[k] = {{(PROD_W-COEF_W){coef_row[k*COEF_W + COEF_W - 1]}},
                        coef_row[k*COEF_W +: COEF_W]};
        end
        p_ext[0] = {{(PROD_W-PIX_W){1'b0}}, pix_r};
        p_ext[1] = {{(PROD_W-PIX_W){1'b0}}, pix_g};
        p_ext[2] = {{(PROD_W-PIX_W){1'b0}}, pix_b};
        off_ext  = {{(ACC_W-COEF_W){coef_row[4*COEF_W - 1]}}, coef_row[3*COEF_W +: COEF_W]};
    end

    // Align the whole-unit offset to the fraction point and fold in the rounding half.
    always_comb begin
        if (fmt_sel) off_term = (off_ext <<< FRAC_F1) + HALF_F1;
        else         off_term = (off_ext <<< FRAC_F0) + HALF_F0;
    end

    // Stage 1: register the three products and the offset term.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 3; k++) s1_prod[k] <= '0;
            s1_off  <= '0;
            s1_byp  <= 1'b1;
            s1_fmt  <= 1'b0;
            s1_pass <= '0;
        end else begin
            for (int k = 0; k < 3; k++) s1_prod[k] <= c_ext[k] * p_ext[k];
            s1_off  <= off_term;
            s1_byp  <= bypass;
            s1_fmt  <= fmt_sel;
            s1_pass <= pix_pass;
        end
    end

    // Stage 2: sum the products with the offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_sum  <= '0;
            s2_byp  <= 1'b1;
            s2_fmt  <= 1'b0;
            s2_pass <= '0;
        end else begin
            s2_sum  <= ACC_W'(s1_prod[0]) + ACC_W'(s1_prod[1]) + ACC_W'(s1_prod[2]) + s1_off;
            s2_byp  <= s1_byp;
            s2_fmt  <= s1_fmt;
            s2_pass <= s1_pass;
        end
    end

    // Drop the fraction bits and saturate to the unsigned pixel range.
    always_comb begin
        shifted = s2_fmt ? (s2_sum >>> FRAC_F1) : (s2_sum >>> FRAC_F0);
        if (shifted < 0)                        clamped = '0;
        else if (shifted > ACC_W'(MAX_PIX))     clamped = '1;
        else                                    clamped = shifted[PIX_W-1:0];
    end

    // Stage 3: register either the clamped result or the bypassed component.
    always_ff @(posedge clk) begin
        if (!rst_n) pix_out <= '0;
        else        pix_out <= s2_byp ? s2_pass : clamped;
    end

endmodule

// File: rtl/rgb_remap_matrix.sv
`timescale 1ns/1ps
// Dual-bank 3x4 colour matrix stage. Coefficient banks A and B are loaded
// through a word write port; the active bank, bypass and format change only
// on frame_start. Fixed latency of three cycles for every mode.
module rgb_remap_matrix
    import remap_pkg::*;
#(
    parameter int PIX_W   = 12,
    parameter int COEF_W  = 16,
    parameter int FRAC_F0 = 13,
    parameter int FRAC_F1 = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_wr_set,
    input  logic [2:0]        cfg_wr_word,
    input  logic [2*COEF_W-1:0] cfg_wr_data,
    input  logic [1:0]        mode_req,
    input  logic              fmt_req,
    input  logic              frame_start,
    input  logic              pix_valid_in,
    input  logic [PIX_W-1:0]  pix_r_in,
    input  logic [PIX_W-1:0]  pix_g_in,
    input  logic [PIX_W-1:0]  pix_b_in,
    output logic              pix_valid_out,
    output logic [PIX_W-1:0]  pix_r_out,
    output logic [PIX_W-1:0]  pix_g_out,
    output logic [PIX_W-1:0]  pix_b_out,
    output logic [1:0]        mode_active
);
    localparam int CHANS    = 3;
    localparam int ROW_LEN  = 4;
    localparam int NUM_COEF = CHANS * ROW_LEN;
    localparam int LATENCY  = 3;

    remap_mode_e                     cur_mode;
    logic                            cur_fmt;
    logic [NUM_COEF*COEF_W-1:0]      coefs;
    logic [CHANS-1:0][PIX_W-1:0]     pix_in_arr;
    logic [CHANS-1:0][PIX_W-1:0]     pix_out_arr;
    logic [LATENCY-1:0]              valid_pipe;

    remap_mode_ctrl u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .mode_code  (mode_req),
        .fmt_code   (fmt_req),
        .cur_mode   (cur_mode),
        .cur_fmt    (cur_fmt)
    );

    remap_coef_store #(.COEF_W(COEF_W), .NUM_COEF(NUM_COEF)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_bank (cfg_wr_set),
        .wr_word (cfg_wr_word),
        .wr_data (cfg_wr_data),
        .rd_bank (cur_mode == MODE_SET_B),
        .rd_coefs(coefs)
    );

    assign pix_in_arr = {pix_b_in, pix_g_in, pix_r_in};

    for (genvar ch = 0; ch < CHANS; ch++) begin : g_lane
        remap_lane #(.PIX_W(PIX_W), .COEF_W(COEF_W),
                     .FRAC_F0(FRAC_F0), .FRAC_F1(FRAC_F1)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .bypass  (cur_mode == MODE_BYPASS),
            .fmt_sel (cur_fmt),
            .coef_row(coefs[ch*ROW_LEN*COEF_W +: ROW_LEN*COEF_W]),
            .pix_r   (pix_r_in),
            .pix_g   (pix_g_in),
            .pix_b   (pix_b_in),
            .pix_pass(pix_in_arr[ch]),
            .pix_out (pix_out_arr[ch])
        );
    end

    // Carry the valid flag beside the data through the three stages.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_pipe <= '0;
        else        valid_pipe <= {valid_pipe[LATENCY-2:0], pix_valid_in};
    end

    assign pix_valid_out = valid_pipe[LATENCY-1];
    assign pix_r_out     = pix_out_arr[0];
    assign pix_g_out     = pix_out_arr[1];
    assign pix_b_out     = pix_out_arr[2];
    assign mode_active   = cur_mode;

    p_valid_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_in |=> ##2 pix_valid_out);

    p_bypass_passthrough_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_in && mode_active == 2'd0) |=> ##2
        (pix_r_out == $past(pix_r_in, 3) && pix_g_out == $past(pix_g_in, 3)
         && pix_b_out == $past(pix_b_in, 3)));

    p_mode_never_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_active != 2'd3);

endmodule

// File: tb/rgb_remap_matrix_test.sv
`timescale 1ns/1ps
module rgb_remap_matrix_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0, cfg_wr_set = 1'b0;
    logic [2:0]  cfg_wr_word = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [1:0]  mode_req = '0;
    logic        fmt_req = 1'b0, frame_start = 1'b0;
    logic        pix_valid_in = 1'b0;
    logic [11:0] pix_r_in = '0, pix_g_in = '0, pix_b_in = '0;
    logic        pix_valid_out;
    logic [11:0] pix_r_out, pix_g_out, pix_b_out;
    logic [1:0]  mode_active;

    int total = 0, bad = 0;
    bit done = 0;
    int mdl_mode = 0, mdl_fmt = 0;
    logic signed [15:0] bank_a [12];
    logic signed [15:0] bank_b [12];

    always #4 clk = ~clk;

    rgb_remap_matrix uut (.*);

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected channel value computed from the requirement formulas.
    function automatic int model(input int lane, input int r, input int g, input int b);
        int pix[3];
        longint acc;
        int frac;
        logic signed [15:0] c [4];
        pix = '{r, g, b};
        if (mdl_mode == 0) return pix[lane];
        for (int j = 0; j < 4; j++) c[j] = (mdl_mode == 1) ? bank_a[lane*4+j] : bank_b[lane*4+j];
        frac = (mdl_fmt == 1) ? 12 : 13;
        acc = longint'(c[0])*r + longint'(c[1])*g + longint'(c[2])*b
            + (longint'(c[3]) <<< frac) + (longint'(1) <<< (frac-1));
        acc = acc >>> frac;
        if (acc < 0) return 0;
        if (acc > 4095) return 4095;
        return int'(acc);
    endfunction

    task automatic write_word(input bit set, input int word, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en = 1; cfg_wr_set = set; cfg_wr_word = word[2:0]; cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 0;
    endtask

    task automatic load_bank(input bit set, input logic signed [15:0] c [12]);
        for (int w = 0; w < 6; w++) write_word(set, w, {c[2*w+1], c[2*w]});
        if (set) bank_b = c; else bank_a = c;
    endtask

    task automatic new_frame(input int code, input int fmt);
        @(negedge clk);
        mode_req = code[1:0]; fmt_req = fmt[0]; frame_start = 1;
        @(negedge clk);
        frame_start = 0;
        mdl_mode = (code == 3) ? 0 : code;
        mdl_fmt = fmt;
    endtask

    task automatic push_check(input string req, input int r, input int g, input int b);
        @(negedge clk);
        pix_valid_in = 1; pix_r_in = r[11:0]; pix_g_in = g[11:0]; pix_b_in = b[11:0];
        @(negedge clk);
        pix_valid_in = 0;
        @(negedge clk);
        @(negedge clk);
        chk({req, " valid"}, int'(pix_valid_out), 1);
        chk({req, " red"}, int'(pix_r_out), model(0, r, g, b));
        chk({req, " green"}, int'(pix_g_out), model(1, r, g, b));
        chk({req, " blue"}, int'(pix_b_out), model(2, r, g, b));
    endtask

    task automatic t_reset;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 mode", int'(mode_active), 0);
        chk("R1 valid", int'(pix_valid_out), 0);
        chk("R1 pixel", int'(pix_r_out | pix_g_out | pix_b_out), 0);
    endtask

    task automatic t_no_frame_hold;
        logic signed [15:0] c [12];
        c = '{16'sd8192, 16'sd0, 16'sd0, 16'sd10,
              16'sd0, 16'sd8192, 16'sd0, -16'sd5,
              16'sd0, 16'sd0, 16'sd8192, 16'sd0};
        load_bank(0, c);
        @(negedge clk);
        mode_req = 2'd1;
        repeat (3) @(negedge clk);
        chk("R2 mode held without frame", int'(mode_active), 0);
        push_check("R2 R4 still bypass", 100, 200, 300);
    endtask

    task automatic t_set_a;
        new_frame(1, 0);
        chk("R2 R3 mode A loaded", int'(mode_active), 1);
        push_check("R5 R10 set A", 100, 200, 300);
        push_check("R5 set A", 4000, 17, 1);
        push_check("R7 clamp low", 0, 2, 0);
    endtask

    task automatic t_idle_write_then_b;
        logic signed [15:0] c [12];
        c = '{16'sd0, 16'sd0, 16'sd8192, 16'sd0,
              16'sd4096, 16'sd4096, 16'sd0, 16'sd0,
              16'sd8192, 16'sd0, 16'sd0, 16'sd0};
        load_bank(1, c);
        push_check("R9 idle write invisible", 100, 200, 301);
        new_frame(2, 0);
        chk("R3 mode B loaded", int'(mode_active), 2);
        push_check("R10 set B swap", 100, 200, 301);
        push_check("R7 round half up", 101, 200, 7);
        write_word(1, 6, 32'h7fff_7fff);
        push_check("R5 word 6 ignored", 101, 200, 7);
    endtask

    task automatic t_format;
        new_frame(1, 1);
        push_check("R6 format 1 gain", 100, 200, 300);
        push_check("R7 clamp high", 4000, 4095, 4095);
        @(negedge clk);
        fmt_req = 1'b0;
        push_check("R2 R6 format held", 100, 200, 300);
    endtask

    task automatic t_reserved;
        new_frame(3, 0);
        chk("R3 reserved reads 0", int'(mode_active), 0);
        push_check("R3 R4 reserved bypass", 4095, 0, 1234);
    endtask

    task automatic t_bypass_keeps;
        new_frame(0, 0);
        push_check("R4 bypass", 7, 8, 9);
        new_frame(2, 0);
        push_check("R9 set B intact", 100, 200, 301);
        new_frame(1, 0);
        push_check("R9 set A intact", 100, 200, 300);
    endtask

    task automatic t_stream;
        int rr[8], gg[8], bb[8];
        for (int i = 0; i < 8; i++) begin
            rr[i] = 50*i + 3; gg[i] = 400 - 30*i; bb[i] = 11*i*i;
        end
        for (int cyc = 0; cyc < 11; cyc++) begin
            @(negedge clk);
            if (cyc >= 3) begin
                chk("R8 stream valid", int'(pix_valid_out), (cyc < 11) ? 1 : 0);
                chk("R8 stream red", int'(pix_r_out), model(0, rr[cyc-3], gg[cyc-3], bb[cyc-3]));
                chk("R8 stream blue", int'(pix_b_out), model(2, rr[cyc-3], gg[cyc-3], bb[cyc-3]));
            end
            if (cyc < 8) begin
                pix_valid_in = 1;
                pix_r_in = rr[cyc][11:0]; pix_g_in = gg[cyc][11:0]; pix_b_in = bb[cyc][11:0];
            end else begin
                pix_valid_in = 0;
            end
        end
        @(negedge clk);
        chk("R8 valid drops", int'(pix_valid_out), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 12; k++) begin bank_a[k] = 0; bank_b[k] = 0; end
        t_reset();
        t_no_frame_hold();
        t_set_a();
        t_idle_write_then_b();
        t_format();
        t_reserved();
        t_bypass_keeps();
        t_stream();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule